// File: doc/BRIEF.md
# Full-Decode Programmable OR-Plane Array

This block is a small programmable logic array with four inputs and four outputs. A fixed AND plane builds every one of the sixteen minterms from the inputs and their inversions. A programmable OR plane holds sixteen crosspoint bits for each output and ORs together the minterms those bits enable. Any four-input function can therefore be placed on any output, with no limit on how many product terms it uses.

The 64-bit program is loaded in one clock through a write port that has a strobe, and a synchronous reset clears it. The outputs follow the inputs combinationally, so a new input pattern is visible in the same cycle. A new program takes effect after the clock edge that loads it.

Top module: `pla_or_plane_top`

## Requirements
- R1: A synchronous reset clears all 64 crosspoint bits, so after reset every output reads 0 for every input value.
- R2: Minterm k is active exactly when the input vector {in_bits[3], in_bits[2], in_bits[1], in_bits[0]} equals k, and exactly one minterm is active at any time.
- R3: Output j is 1 exactly when the crosspoint bit at index 16*j + k of the program is 1, where k is the current input value. A disabled crosspoint (bit 0) contributes 0.
- R4: When prog_we is 1 at a rising clock edge and reset is low, the whole program is replaced by prog_data, and the outputs reflect it from that edge on.
- R5: When prog_we is 0, changes on prog_data have no effect on the program or the outputs.
- R6: An output whose 16 crosspoint bits are all 0 reads 0 for every input value.
- R7: Enabling the eight minterms of odd parity on one output (column value 16'h6996) makes that output the XOR of all four inputs.
- R8: An output whose 16 crosspoint bits are all 1 reads 1 for every input value.
- R9: The crosspoint bits of one output have no effect on any other output.
- R10: When reset and prog_we are both 1 at the same edge, reset wins and the program is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the program register |
| rst | input | 1 | Synchronous active-high reset, clears the program |
| in_bits | input | 4 | Logic inputs; bit 0 is the least significant bit of the minterm index |
| prog_we | input | 1 | Program write strobe |
| prog_data | input | 64 | New program; bit 16*j + k enables minterm k on output j |
| out_bits | output | 4 | Combinational outputs, one per OR column |

## Verification
The clocked assertions assume that reset is high from time zero until at least one clock edge, so the program register holds a defined value before any property that looks at the previous cycle is enabled. They also assume inputs and the write strobe change only away from the rising edge. The bench holds reset from the start, drives every input on the falling edge, and sweeps the input value on even nanosecond offsets so no sample or change lands on a rising edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int unsigned PLA_NUM_IN  = 4;
    localparam int unsigned PLA_NUM_OUT = 4;
    localparam int unsigned PLA_TERMS   = 1 << PLA_NUM_IN;
    localparam int unsigned PLA_PROG_W  = PLA_TERMS * PLA_NUM_OUT;

    typedef logic [PLA_NUM_IN-1:0]  in_vec_t;
    typedef logic [PLA_TERMS-1:0]   term_vec_t;
    typedef logic [PLA_NUM_OUT-1:0] out_vec_t;
    typedef logic [PLA_PROG_W-1:0]  prog_vec_t;

    // One write request to the crosspoint store.
    typedef struct packed {
        logic      we;
        prog_vec_t data;
    } prog_req_t;

    // Bit position of the crosspoint joining minterm k to output j.
    function automatic int unsigned xpt_index(int unsigned out_j, int unsigned term_k);
        return out_j * PLA_TERMS + term_k;
    endfunction
endpackage

// File: rtl/pla_minterm_decoder.sv
module pla_minterm_decoder #(
    parameter int unsigned NUM_IN = pla_pkg::PLA_NUM_IN,
    localparam int unsigned TERMS = 1 << NUM_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] in_i,
    output logic [TERMS-1:0]  term_o
);
    // True and inverted literals feed every product term.
    logic [NUM_IN-1:0] lit_true;
    logic [NUM_IN-1:0] lit_inv;

    assign lit_true = in_i;
    assign lit_inv  = ~in_i;

    for (genvar k = 0; k < TERMS; k++) begin : g_term
        logic [NUM_IN-1:0] picked;
        for (genvar b = 0; b < NUM_IN; b++) begin : g_lit
            if (((k >> b) & 1) == 1) begin : g_pos
                assign picked[b] = lit_true[b];
            end else begin : g_neg
                assign picked[b] = lit_inv[b];
            end
        end
        assign term_o[k] = &picked;
    end

    // R2: the term indexed by the input is the only active one.
    assert_single_term_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot(term_o) && term_o[in_i]);
endmodule

// File: rtl/pla_prog_store.sv
module pla_prog_store
    import pla_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  prog_req_t req_i,
    output prog_vec_t prog_o
);
    prog_vec_t prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= '0;
        end else if (req_i.we) begin
            prog_q <= req_i.data;
        end
    end

    assign prog_o = prog_q;

    // R1 / R10: reset leaves an empty program, even with a write pending.
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (prog_o == '0));

    // R4: a strobed write lands in full on the next edge.
    assert_write_loads_R4: assert property (@(posedge clk) disable iff (rst)
        req_i.we |=> (prog_o == $past(req_i.data)));

    // R5: without the strobe the program does not move.
    assert_hold_without_we_R5: assert property (@(posedge clk) disable iff (rst)
        !req_i.we |=> $stable(prog_o));
endmodule

// File: rtl/pla_or_column.sv
module pla_or_column #(
    parameter int unsigned TERMS = pla_pkg::PLA_TERMS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TERMS-1:0] enable_i,
    input  logic [TERMS-1:0] term_i,
    output logic             out_o
);
    // A cleared crosspoint gates its minterm to 0 before the OR.
    logic [TERMS-1:0] gated;

    assign gated = enable_i & term_i;
    assign out_o = |gated;

    // R6: an empty column never drives a 1.
    assert_empty_column_R6: assert property (@(posedge clk) disable iff (rst)
        (enable_i == '0) |-> !out_o);

    // R8: a full column always drives a 1 (one minterm is always live).
    assert_full_column_R8: assert property (@(posedge clk) disable iff (rst)
        (&enable_i) |-> out_o);
endmodule

// File: rtl/pla_or_plane_top.sv
module pla_or_plane_top
    import pla_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PLA_NUM_IN-1:0] in_bits,
    input  logic                  prog_we,
    input  logic [PLA_PROG_W-1:0] prog_data,
    output logic [PLA_NUM_OUT-1:0] out_bits
);
    prog_req_t wr_req;
    prog_vec_t prog;
    term_vec_t terms;
    out_vec_t  col_out;

    assign wr_req.we   = prog_we;
    assign wr_req.data = prog_data;

    pla_prog_store u_store (
        .clk    (clk),
        .rst    (rst),
        .req_i  (wr_req),
        .prog_o (prog)
    );

    pla_minterm_decoder #(.NUM_IN(PLA_NUM_IN)) u_and_plane (
        .clk    (clk),
        .rst    (rst),
        .in_i   (in_bits),
        .term_o (terms)
    );

    for (genvar j = 0; j < PLA_NUM_OUT; j++) begin : g_col
        pla_or_column #(.TERMS(PLA_TERMS)) u_col (
            .clk      (clk),
            .rst      (rst),
            .enable_i (prog[j*PLA_TERMS +: PLA_TERMS]),
            .term_i   (terms),
            .out_o    (col_out[j])
        );

        // R3: a high output needs its crosspoint at the live minterm set.
        assert_out_needs_xpt_R3: assert property (@(posedge clk) disable iff (rst)
            col_out[j] |-> prog[xpt_index(j, in_bits)]);

        // R9: with its crosspoint cleared, an output stays low whatever the rest hold.
        assert_column_isolated_R9: assert property (@(posedge clk) disable iff (rst)
            !prog[xpt_index(j, in_bits)] |-> !col_out[j]);
    end

    assign out_bits = col_out;
endmodule

// File: tb/pla_or_plane_top_tb_top.sv
module pla_or_plane_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  in_bits = '0;
    logic        prog_we = 1'b0;
    logic [63:0] prog_data = '0;
    logic [3:0]  out_bits;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_or_plane_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_bits   (in_bits),
        .prog_we   (prog_we),
        .prog_data (prog_data),
        .out_bits  (out_bits)
    );

    function automatic logic [3:0] expect_out(logic [63:0] p, logic [3:0] v);
        logic [3:0] r;
        for (int j = 0; j < 4; j++) r[j] = p[16*j + int'(v)];
        return r;
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: out_bits=%b expected=%b in=%0d", tag, act, exp, in_bits);
        end
    endtask

    task automatic load(input logic [63:0] d);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_data = d;
        @(negedge clk);
        prog_we   = 1'b0;
        model     = d;
    endtask

    // Walks all 16 input values on even offsets from a falling edge.
    task automatic sweep(input string tag);
        @(negedge clk);
        for (int v = 0; v < 16; v++) begin
            in_bits = 4'(v);
            #2;
            check(out_bits, expect_out(model, 4'(v)), tag);
        end
    endtask

    task automatic t_reset;
        model = '0;
        sweep("R1 reset state");
    endtask

    task automatic t_mixed;
        load(64'hA5C3_0FF0_1234_8001);
        sweep("R3/R4 mixed program");
        load(64'h0000_FFFF_0000_FFFF);
        sweep("R4 reload replaces program");
    endtask

    task automatic t_single_term;
        for (int k = 0; k < 16; k += 5) begin
            load(64'(1) << (16 + k));
            sweep("R2 single minterm on output 1");
        end
    endtask

    task automatic t_hold;
        load(64'h0F0F_3333_5555_00FF);
        @(negedge clk);
        prog_data = ~prog_data;
        repeat (2) @(negedge clk);
        sweep("R5 data ignored without strobe");
    endtask

    task automatic t_xor;
        load(64'h6996 << 32);
        @(negedge clk);
        for (int v = 0; v < 16; v++) begin
            in_bits = 4'(v);
            #2;
            check(out_bits, {1'b0, ^4'(v), 2'b00}, "R7 xor on output 2");
        end
    endtask

    task automatic t_full_and_empty;
        load(64'hFFFF_0000_FFFF_0000);
        sweep("R6/R8 full and empty columns");
        @(negedge clk);
        for (int v = 0; v < 16; v++) begin
            in_bits = 4'(v);
            #2;
            check(out_bits, 4'b1010, "R8 full columns read 1, R6 empty read 0");
        end
    endtask

    task automatic t_isolation;
        load(64'h0000_0000_0000_BEEF);
        @(negedge clk);
        for (int v = 0; v < 16; v++) begin
            in_bits = 4'(v);
            #2;
            check({out_bits[3:1], 1'b0}, 4'b0000, "R9 other outputs unaffected");
        end
        sweep("R9 column 0 only");
    endtask

    task automatic t_reset_wins;
        load(64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        rst       = 1'b1;
        prog_we   = 1'b1;
        prog_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        rst     = 1'b0;
        prog_we = 1'b0;
        model   = '0;
        sweep("R10 reset beats write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mixed();
        t_single_term();
        t_hold();
        t_xor();
        t_full_and_empty();
        t_isolation();
        t_reset_wins();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule